// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps local host addresses onto a wider peripheral bus address space through a small bank of programmable windows. Each window holds a translation page number, an upper-address extension word, a base page number and an attribute word. The attribute word carries an enable bit, a size code, and separate transaction-type codes for reads and writes. Base and translation addresses are kept at 4 KiB granularity. A size code of k describes a window of 2^(k+1) bytes.

Every lookup compares the local address against all windows at once. The lowest-numbered matching window among windows 1 and up is selected. Window 0 is a catch-all that serves any address no other window claims. The output address keeps the in-window offset bits of the local address, takes the bits above them from the translation page, and takes its upper 32 bits from the extension word. The response also reports the transaction-type code for the access direction and the index of the selected window. Results are registered, so each response appears one cycle after its request.

Top module: `owin_xlate`

## Requirements
- R1: After reset every window register reads back as zero, and `rsp_valid`, `rsp_hit`, `rsp_win`, `rsp_type` and `rsp_addr` are all zero.
- R2: `cfg_word[5:2]` selects the window and `cfg_word[1:0]` selects the register within it: 0 is the translation page, 1 the extension word, 2 the base page, 3 the attributes. The page registers keep bits [19:0]. The attribute register keeps bit 31 (enable), bits [19:16] (read type), bits [15:12] (write type) and bits [5:0] (size code), so a write of all ones reads back as 0x800FF03F. All other bits read as zero. A window index at or above NUM_WIN ignores writes and reads as zero.
- R3: Window n (n ≥ 1) matches only when its enable bit is 1, its size code is at least 11, and the local address with the low (code+1) bits cleared equals the base page shifted left by 12. A window with a size code below 11 never matches.
- R4: When several windows numbered 1 and up match, the one with the lowest index is selected.
- R5: Window 0 is selected when no other window matches, provided it is enabled with a size code of at least 11; its base is not compared. If window 0 is not usable either, the response has `rsp_hit` = 0 and zero window, type and address.
- R6: On a hit, `rsp_addr[31:0]` has local address bits [code:0] and translation-page-shifted-left-by-12 bits above them, and `rsp_addr[63:32]` equals the window's extension word.
- R7: On a hit, `rsp_type` is the write-type field when `req_write` is 1 and the read-type field otherwise; a memory window programmed as 0x80044000 plus size yields 4, an I/O window programmed as 0x80088000 plus size yields 8.
- R8: A request presented with `req_valid` at a clock edge produces its response at the next edge: `rsp_valid` is `req_valid` delayed by one cycle, and an idle cycle drives all response fields to zero.
- R9: Size codes of 31 and above cover the whole 32-bit local space: every address matches and all 32 low bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_word | input | 6 | Register word index: window in [5:2], register in [1:0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_word` (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Local address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window was selected |
| rsp_win | output | 3 | Index of the selected window |
| rsp_type | output | 4 | Transaction-type code of the selected window |
| rsp_addr | output | 64 | Translated peripheral bus address |

## Verification
Some properties are checked on every cycle. These are the one-cycle latency from request to response, the zeroed fields of a miss or an idle cycle, and a selected window index that is always in range. Another per-cycle check is that the low 12 offset bits of every hit equal those of the address captured a cycle earlier. Priority among overlapping windows, the window 0 fallback, the size-code threshold, the full-space sizes, and the register masking and out-of-range indices all depend on how the windows are programmed. Those only appear in the bench's directed and random scenarios, which compare each response against a model of the programmed windows.

// File: rtl/owin_pkg.sv
package owin_pkg;

    localparam int LADDR_W       = 32;
    localparam int PAGE_W        = 12;
    localparam int PFN_W         = LADDR_W - PAGE_W;
    localparam int EXT_W         = 32;
    localparam int CDATA_W       = 32;
    localparam int SIZE_W        = 6;
    localparam int TYPE_W        = 4;
    localparam int CFG_W         = 6;
    localparam int OADDR_W       = EXT_W + LADDR_W;
    localparam int MIN_SIZE_CODE = PAGE_W - 1;

    typedef enum logic [1:0] {
        SEL_XLAT = 2'd0,
        SEL_XEXT = 2'd1,
        SEL_BASE = 2'd2,
        SEL_ATTR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [TYPE_W-1:0] rd_ty;
        logic [TYPE_W-1:0] wr_ty;
        logic [SIZE_W-1:0] size;
    } attr_t;

    typedef struct packed {
        logic [EXT_W-1:0] xext;
        logic [PFN_W-1:0] xlat;
        logic [PFN_W-1:0] base;
        attr_t            attr;
    } win_t;

    // Offset mask of a window: bits 0..code set, saturating at the full width.
    function automatic logic [LADDR_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
        logic [LADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < LADDR_W; b++) begin
            if (b <= int'(code)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/owin_regs.sv
module owin_regs
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_word,
    input  logic [CDATA_W-1:0]      cfg_wdata,
    output logic [CDATA_W-1:0]      cfg_rdata,
    output win_t [NUM_WIN-1:0]      win_o
);

    localparam int IDX_W = CFG_W - 2;

    win_t [NUM_WIN-1:0] win_d, win_q;
    logic [IDX_W-1:0]   idx;
    reg_sel_e           sel;

    assign idx = cfg_word[CFG_W-1:2];
    assign sel = reg_sel_e'(cfg_word[1:0]);

    always_comb begin
        win_d = win_q;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (cfg_we && int'(idx) == w) begin
                case (sel)
                    SEL_XLAT: win_d[w].xlat = cfg_wdata[PFN_W-1:0];
                    SEL_XEXT: win_d[w].xext = cfg_wdata[EXT_W-1:0];
                    SEL_BASE: win_d[w].base = cfg_wdata[PFN_W-1:0];
                    default: begin
                        win_d[w].attr.en    = cfg_wdata[31];
                        win_d[w].attr.rd_ty = cfg_wdata[19:16];
                        win_d[w].attr.wr_ty = cfg_wdata[15:12];
                        win_d[w].attr.size  = cfg_wdata[SIZE_W-1:0];
                    end
                endcase
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (int'(idx) == w) begin
                case (sel)
                    SEL_XLAT: cfg_rdata = {{(CDATA_W-PFN_W){1'b0}}, win_q[w].xlat};
                    SEL_XEXT: cfg_rdata = win_q[w].xext;
                    SEL_BASE: cfg_rdata = {{(CDATA_W-PFN_W){1'b0}}, win_q[w].base};
                    default:  cfg_rdata = {win_q[w].attr.en, 11'b0,
                                           win_q[w].attr.rd_ty, win_q[w].attr.wr_ty,
                                           6'b0, win_q[w].attr.size};
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_o = win_q;

endmodule

// File: rtl/owin_match.sv
module owin_match
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  win_t [NUM_WIN-1:0] win_i,
    input  logic [LADDR_W-1:0] req_addr,
    output logic [NUM_WIN-1:0] hit_o
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic               usable;
        logic [LADDR_W-1:0] mask;
        logic [LADDR_W-1:0] base_addr;

        assign usable    = win_i[i].attr.en && (win_i[i].attr.size >= SIZE_W'(MIN_SIZE_CODE));
        assign mask      = size_mask(win_i[i].attr.size);
        assign base_addr = {win_i[i].base, {PAGE_W{1'b0}}};

        if (i == 0) begin : g_default
            // catch-all: no base compare, priority resolved downstream
            assign hit_o[i] = usable;
        end else begin : g_cmp
            assign hit_o[i] = usable && (((req_addr ^ base_addr) & ~mask) == '0);
        end
    end

endmodule

// File: rtl/owin_select.sv
module owin_select
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  win_t [NUM_WIN-1:0] win_i,
    input  logic [NUM_WIN-1:0] hit_i,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_addr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WIN_W-1:0]   rsp_win,
    output logic [TYPE_W-1:0]  rsp_type,
    output logic [OADDR_W-1:0] rsp_addr
);

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [WIN_W-1:0]   win;
        logic [TYPE_W-1:0]  ty;
        logic [OADDR_W-1:0] addr;
    } rsp_t;

    rsp_t               rsp_d, rsp_q;
    logic [WIN_W-1:0]   pick;
    logic               found;
    win_t               chosen;
    logic [LADDR_W-1:0] mask;
    logic [LADDR_W-1:0] low_addr;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = NUM_WIN - 1; i >= 1; i--) begin
            if (hit_i[i]) begin
                pick  = WIN_W'(i);
                found = 1'b1;
            end
        end
        if (!found && hit_i[0]) found = 1'b1;

        chosen = win_i[0];
        for (int i = 1; i < NUM_WIN; i++) begin
            if (int'(pick) == i) chosen = win_i[i];
        end

        mask     = size_mask(chosen.attr.size);
        low_addr = ({chosen.xlat, {PAGE_W{1'b0}}} & ~mask) | (req_addr & mask);

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid && found) begin
            rsp_d.hit  = 1'b1;
            rsp_d.win  = pick;
            rsp_d.ty   = req_write ? chosen.attr.wr_ty : chosen.attr.rd_ty;
            rsp_d.addr = {chosen.xext, low_addr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_win   = rsp_q.win;
    assign rsp_type  = rsp_q.ty;
    assign rsp_addr  = rsp_q.addr;

endmodule

// File: rtl/owin_xlate.sv
module owin_xlate
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [CDATA_W-1:0] cfg_wdata,
    output logic [CDATA_W-1:0] cfg_rdata,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_addr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WIN_W-1:0]   rsp_win,
    output logic [TYPE_W-1:0]  rsp_type,
    output logic [OADDR_W-1:0] rsp_addr
);

    win_t [NUM_WIN-1:0] win;
    logic [NUM_WIN-1:0] hit;

    owin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_o     (win)
    );

    owin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win_i    (win),
        .req_addr (req_addr),
        .hit_o    (hit)
    );

    owin_select #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_i     (win),
        .hit_i     (hit),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_win   (rsp_win),
        .rsp_type  (rsp_type),
        .rsp_addr  (rsp_addr)
    );

endmodule

// File: rtl/owin_xlate_chk.sv
module owin_xlate_chk
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [LADDR_W-1:0] req_addr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [WIN_W-1:0]   rsp_win,
    input logic [TYPE_W-1:0]  rsp_type,
    input logic [OADDR_W-1:0] rsp_addr
);

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_addr == '0 && rsp_type == '0));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_type == '0 && rsp_win == '0));

    // R4
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_win <= WIN_W'(NUM_WIN - 1)));

    // R6
    page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0])));

    // R1
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);

endmodule

bind owin_xlate owin_xlate_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (.*);

// File: tb/tb_owin_xlate.sv
`timescale 1ns/1ps
module tb_owin_xlate;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_type;
    logic [63:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] m_xlat [NW];
    logic [31:0] m_xext [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_attr [NW];

    always #2 clk = ~clk;

    owin_xlate #(.NUM_WIN(NW)) dut (.*);

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_mask(input logic [5:0] k);
        logic [63:0] m;
        m = (64'd1 << (int'(k) + 1)) - 64'd1;
        return (k >= 6'd31) ? 32'hFFFF_FFFF : m[31:0];
    endfunction

    // expected {hit, win[2:0], type[3:0], addr[63:0]}
    function automatic logic [71:0] predict(input logic [31:0] a, input logic wr);
        int sel;
        logic [31:0] mk;
        logic [3:0]  ty;
        sel = -1;
        for (int i = NW - 1; i >= 1; i--) begin
            mk = mk_mask(m_attr[i][5:0]);
            if (m_attr[i][31] && m_attr[i][5:0] >= 6'd11 &&
                ((a & ~mk) == ({m_base[i][19:0], 12'h000} & ~mk)))
                sel = i;
        end
        if (sel < 0 && m_attr[0][31] && m_attr[0][5:0] >= 6'd11) sel = 0;
        if (sel < 0) return '0;
        mk = mk_mask(m_attr[sel][5:0]);
        ty = wr ? m_attr[sel][15:12] : m_attr[sel][19:16];
        return {1'b1, 3'(sel), ty, m_xext[sel],
                ({m_xlat[sel][19:0], 12'h000} & ~mk) | (a & mk)};
    endfunction

    task automatic wr_reg(input int w, input int r, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = {4'(w), 2'(r)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (w < NW) begin
            case (r)
                0: m_xlat[w] = d & 32'h000F_FFFF;
                1: m_xext[w] = d;
                2: m_base[w] = d & 32'h000F_FFFF;
                default: m_attr[w] = d & 32'h800F_F03F;
            endcase
        end
    endtask

    task automatic rd_check(input int w, input int r, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_word = {4'(w), 2'(r)};
        #0.5;
        check(cfg_rdata == exp, req, {40'b0, cfg_rdata}, {40'b0, exp});
    endtask

    task automatic look(input logic [31:0] a, input logic wr, input string req);
        logic [71:0] exp, act;
        exp = predict(a, wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        act = {rsp_hit, rsp_win, rsp_type, rsp_addr};
        check(rsp_valid && act == exp, req, act, exp);
        req_valid = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int w;
        for (int i = 0; i < NW; i++) begin
            m_xlat[i] = '0; m_xext[i] = '0; m_base[i] = '0; m_attr[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of registers and response
        for (int i = 0; i < NW; i++)
            for (int r = 0; r < 4; r++) rd_check(i, r, 32'h0, "R1 reg reset");
        check(!rsp_valid && !rsp_hit && rsp_addr == '0, "R1 rsp reset",
              {62'b0, rsp_valid, rsp_hit, rsp_addr[7:0]}, '0);

        // R2: masking and readback
        wr_reg(4, 3, 32'hFFFF_FFFF);
        rd_check(4, 3, 32'h800F_F03F, "R2 attr mask");
        wr_reg(4, 0, 32'hFFFF_FFFF);
        rd_check(4, 0, 32'h000F_FFFF, "R2 xlat mask");
        wr_reg(4, 1, 32'hCAFE_0001);
        rd_check(4, 1, 32'hCAFE_0001, "R2 ext full");

        // windows: 1 mem 64KiB, 2 and 3 I/O 4KiB overlapping, 4 too small
        wr_reg(1, 0, 32'h000A_0000); wr_reg(1, 1, 32'h0000_0001);
        wr_reg(1, 2, 32'h0001_0000); wr_reg(1, 3, 32'h8004_400F);
        wr_reg(2, 0, 32'h0000_0300); wr_reg(2, 2, 32'h0001_0000);
        wr_reg(2, 3, 32'h8008_800B);
        wr_reg(3, 0, 32'h0000_0500); wr_reg(3, 1, 32'h0000_0077);
        wr_reg(3, 2, 32'h0001_0000); wr_reg(3, 3, 32'h8008_800B);
        wr_reg(4, 0, 32'h0000_0900); wr_reg(4, 2, 32'h0002_0000);
        wr_reg(4, 3, 32'h8004_400A);
        wr_reg(0, 0, 32'h000F_FF00); wr_reg(0, 1, 32'h0000_DEAD);
        wr_reg(0, 3, 32'h8003_3013);

        // R2: out-of-range index ignored, reads zero, no alias onto window 0
        wr_reg(5, 3, 32'h8000_0000);
        wr_reg(5, 0, 32'h0001_2345);
        rd_check(5, 3, 32'h0, "R2 oob attr");
        rd_check(15, 0, 32'h0, "R2 oob xlat");
        rd_check(0, 3, 32'h8003_3013, "R2 win0 intact");

        look(32'h1000_1234, 1'b0, "R6 R7 mem read win1");
        check(predict(32'h1000_1234, 1'b0) == {1'b1, 3'd1, 4'd4, 64'h1_A000_1234},
              "R6 hand value", predict(32'h1000_1234, 1'b0), {1'b1, 3'd1, 4'd4, 64'h1_A000_1234});
        look(32'h1000_0ABC, 1'b1, "R4 overlap win1 over 2,3");
        wr_reg(1, 3, 32'h0004_400F);
        look(32'h1000_0ABC, 1'b0, "R4 win2 over win3");
        look(32'h1000_5ABC, 1'b1, "R3 outside 4KiB windows");
        look(32'h2000_0010, 1'b1, "R3 size code 10 ignored, R5 default");
        look(32'h2000_0010, 1'b0, "R7 read type win0");

        // R5: no usable default
        wr_reg(0, 3, 32'h0003_3013);
        look(32'h5555_0000, 1'b0, "R5 miss");
        wr_reg(0, 3, 32'h8003_300A);
        look(32'h5555_0000, 1'b0, "R5 default too small");
        wr_reg(0, 3, 32'h8003_3013);

        // R8: idle cycle after a request
        @(negedge clk);
        check(!rsp_valid && !rsp_hit, "R8 idle", {70'b0, rsp_valid, rsp_hit}, '0);

        // random phase
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 7) == 0) begin
                w = $urandom_range(0, NW - 1);
                wr_reg(w, 0, $urandom());
                wr_reg(w, 1, $urandom());
                wr_reg(w, 2, $urandom());
                wr_reg(w, 3, {($urandom_range(0, 3) != 0), 11'b0, 4'($urandom()),
                              4'($urandom()), 6'b0, 6'($urandom_range(8, 34))});
            end
            w = $urandom_range(1, NW - 1);
            if ($urandom_range(0, 1) == 1)
                a = {m_base[w][19:0], 12'h000} ^ ($urandom() & mk_mask(6'($urandom_range(10, 20))));
            else
                a = $urandom();
            look(a, 1'($urandom()), "R3 R4 R5 R6 R7 random");
        end

        // R9: whole-space window
        for (int i = 1; i < NW; i++) wr_reg(i, 3, 32'h0);
        wr_reg(3, 1, 32'h0000_0042);
        wr_reg(3, 3, 32'h8004_4028);
        look(32'h7654_3210, 1'b0, "R9 full space");
        look(32'hFFFF_FFFF, 1'b1, "R9 full space top");
        check(predict(32'h7654_3210, 1'b0) == {1'b1, 3'd3, 4'd4, 64'h42_7654_3210},
              "R9 hand value", predict(32'h7654_3210, 1'b0), {1'b1, 3'd3, 4'd4, 64'h42_7654_3210});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule